// File: doc/BRIEF.md
# Fixed-Point to Signed Integer Rounding Converter

This block turns a sign-and-magnitude fixed-point number into a rounded two's-complement integer in one clock. The magnitude is unsigned. Its lowest `FRAC_W` bits are fraction bits and its top bit must be zero. A two-bit mode selects one of four ways to round. After rounding, the magnitude is negated when the sign is set. The result is then checked against the signed range of the output word.

When the rounded value does not fit, the block returns the integer-indefinite pattern and raises an invalid pulse. Otherwise it returns the rounded integer. An inexact pulse marks a result that lost fraction bits, and a rounded-up pulse marks a result whose magnitude grew during rounding. The flags are not sticky: each set of flags belongs to the result that comes out with it.

It is meant to be the last stage of a float-to-integer conversion path. Decoding the floating-point format happens upstream, and masking or trapping of exceptions happens downstream.

Top module: `fxp_to_int_rounder`

## Requirements
- R1: All outputs are registered. Values sampled at one rising clock edge appear after that edge, and reset (active-low, asynchronous) drives the result to zero and every flag low.
- R2: Mode 2'b00 is round to nearest, ties to even. Half an LSB (1 << (FRAC_W-1)) is added to the magnitude before the fraction is dropped. When the dropped bits equal exactly half, bit 0 of the rounded magnitude is cleared.
- R3: Mode 2'b11 is round toward zero. Nothing is added, so the fraction is simply truncated.
- R4: Mode 2'b01 rounds toward minus infinity and mode 2'b10 rounds toward plus infinity. All-ones in the fraction field is added only when the mode points away from zero for the given sign: 2'b01 with the sign set, or 2'b10 with the sign clear. Otherwise nothing is added.
- R5: When the sign is set, the output is the two's-complement negation of the rounded magnitude.
- R6: The result is invalid in two cases: the rounded magnitude has any bit set at or above bit INT_W, or a nonzero signed result has a sign bit that differs from the input sign. When the result is invalid, invalid_o is high and result_o is 1 << (INT_W-1).
- R7: inexact_o is high exactly when the FRAC_W dropped bits are nonzero and the result is valid.
- R8: rounded_up_o is high exactly when the result is inexact and the rounded magnitude shifted left by FRAC_W exceeds the input magnitude.
- R9: When invalid_o is high, inexact_o and rounded_up_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mag_i | input | MAG_W | Unsigned magnitude, low FRAC_W bits are fraction, top bit zero |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| result_o | output | INT_W | Rounded two's-complement integer or indefinite pattern |
| invalid_o | output | 1 | Result out of range |
| inexact_o | output | 1 | Fraction bits were lost |
| rounded_up_o | output | 1 | Rounded magnitude exceeds exact magnitude |

## Verification
The rounding increment and the range check can act on the same value in the same cycle. This happens when the increment carries an in-range magnitude just past the signed limit. It also happens when a negative value rounds onto the most negative integer, which is still representable. The bench provokes both by sweeping every magnitude with every sign and mode on a narrow configuration. At each of those edges it judges that the indefinite pattern replaces the result and that the inexact and rounded-up pulses are suppressed. It also judges that the most-negative boundary stays valid with its flags intact.

// File: rtl/fxp_round_pkg.sv
package fxp_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

endpackage

// File: rtl/fxp_incr_sel.sv
module fxp_incr_sel
    import fxp_round_pkg::*;
#(
    parameter int FRAC_W = 7
) (
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic [FRAC_W-1:0] inc_o,
    output logic              nearest_o
);
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);
    localparam logic [FRAC_W-1:0] ONES = '1;

    rmode_e mode;
    assign mode = rmode_e'(mode_i);

    always_comb begin
        inc_o     = '0;
        nearest_o = 1'b0;
        unique case (mode)
            RM_NEAREST: begin
                inc_o     = HALF;
                nearest_o = 1'b1;
            end
            RM_DOWN:    inc_o = sign_i ? ONES : '0;
            RM_UP:      inc_o = sign_i ? '0 : ONES;
            RM_ZERO:    inc_o = '0;
            default:    inc_o = '0;
        endcase
    end
endmodule

// File: rtl/fxp_round_core.sv
module fxp_round_core #(
    parameter int MAG_W  = 64,
    parameter int FRAC_W = 7,
    localparam int SUM_W = MAG_W + 1,
    localparam int Q_W   = SUM_W - FRAC_W
) (
    input  logic [MAG_W-1:0]  mag_i,
    input  logic [FRAC_W-1:0] inc_i,
    input  logic              nearest_i,
    output logic [Q_W-1:0]    q_o,
    output logic              lost_o,
    output logic              grew_o
);
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

    logic [SUM_W-1:0]  sum;
    logic [Q_W-1:0]    q_raw;
    logic [FRAC_W-1:0] dropped;
    logic              tie;

    always_comb begin
        sum     = {1'b0, mag_i} + SUM_W'(inc_i);
        q_raw   = sum[SUM_W-1:FRAC_W];
        dropped = mag_i[FRAC_W-1:0];
        tie     = nearest_i && (dropped == HALF);
        q_o     = q_raw & ~Q_W'(tie);
        lost_o  = (dropped != '0);
        grew_o  = {q_o, {FRAC_W{1'b0}}} > {1'b0, mag_i};
    end
endmodule

// File: rtl/fxp_range_pack.sv
module fxp_range_pack #(
    parameter int Q_W   = 58,
    parameter int INT_W = 32
) (
    input  logic             sign_i,
    input  logic [Q_W-1:0]   q_i,
    output logic [INT_W-1:0] value_o,
    output logic             bad_o
);
    logic             high_set;
    logic [INT_W-1:0] low;

    always_comb begin
        high_set = |q_i[Q_W-1:INT_W];
        low      = q_i[INT_W-1:0];
        value_o  = sign_i ? (~low + INT_W'(1)) : low;
        bad_o    = high_set || ((value_o != '0) && (value_o[INT_W-1] ^ sign_i));
    end
endmodule

// File: rtl/fxp_to_int_rounder.sv
module fxp_to_int_rounder #(
    parameter int MAG_W  = 64,
    parameter int FRAC_W = 7,
    parameter int INT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sign_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [1:0]       mode_i,
    output logic [INT_W-1:0] result_o,
    output logic             invalid_o,
    output logic             inexact_o,
    output logic             rounded_up_o
);
    localparam int Q_W = MAG_W + 1 - FRAC_W;
    localparam logic [INT_W-1:0] INDEF = INT_W'(1) << (INT_W - 1);

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
        logic             rnd_up;
    } out_t;

    logic [FRAC_W-1:0] inc;
    logic              nearest;
    logic [Q_W-1:0]    q;
    logic              lost;
    logic              grew;
    logic [INT_W-1:0]  value;
    logic              bad;

    out_t out_d, out_q;

    fxp_incr_sel #(.FRAC_W(FRAC_W)) u_incr (
        .sign_i    (sign_i),
        .mode_i    (mode_i),
        .inc_o     (inc),
        .nearest_o (nearest)
    );

    fxp_round_core #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_core (
        .mag_i     (mag_i),
        .inc_i     (inc),
        .nearest_i (nearest),
        .q_o       (q),
        .lost_o    (lost),
        .grew_o    (grew)
    );

    fxp_range_pack #(.Q_W(Q_W), .INT_W(INT_W)) u_range (
        .sign_i  (sign_i),
        .q_i     (q),
        .value_o (value),
        .bad_o   (bad)
    );

    always_comb begin
        out_d.invalid = bad;
        out_d.value   = bad ? INDEF : value;
        out_d.inexact = lost && !bad;
        out_d.rnd_up  = lost && !bad && grew;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o     = out_q.value;
    assign invalid_o    = out_q.invalid;
    assign inexact_o    = out_q.inexact;
    assign rounded_up_o = out_q.rnd_up;
endmodule

// File: rtl/fxp_to_int_rounder_chk.sv
module fxp_to_int_rounder_chk #(
    parameter int MAG_W  = 64,
    parameter int FRAC_W = 7,
    parameter int INT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sign_i,
    input logic [MAG_W-1:0] mag_i,
    input logic [1:0]       mode_i,
    input logic [INT_W-1:0] result_o,
    input logic             invalid_o,
    input logic             inexact_o,
    input logic             rounded_up_o
);
    localparam logic [INT_W-1:0] INDEF = INT_W'(1) << (INT_W - 1);

    p_indef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (result_o == INDEF));

    p_quiet_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (!inexact_o && !rounded_up_o));

    p_up_needs_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rounded_up_o |-> inexact_o);

    p_trunc_never_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> !rounded_up_o);

    p_exact_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_i[FRAC_W-1:0] == '0) |=> !inexact_o);

    p_sign_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sign_i |=> (invalid_o || result_o == '0 || result_o[INT_W-1]));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0 && !invalid_o && !inexact_o && !rounded_up_o));
endmodule

bind fxp_to_int_rounder fxp_to_int_rounder_chk #(
    .MAG_W(MAG_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
) u_chk (.*);

// File: tb/sim_fxp_to_int_rounder.sv
module sim_fxp_to_int_rounder;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 12;
    localparam int FW = 3;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sign_i = 1'b0;
    logic [MW-1:0] mag_i = '0;
    logic [1:0]    mode_i = 2'b00;
    logic [IW-1:0] result_o;
    logic          invalid_o, inexact_o, rounded_up_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxp_to_int_rounder #(.MAG_W(MW), .FRAC_W(FW), .INT_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .mag_i(mag_i), .mode_i(mode_i),
        .result_o(result_o), .invalid_o(invalid_o), .inexact_o(inexact_o),
        .rounded_up_o(rounded_up_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int flr, frac, rm, v, exp_res;
        bit exp_inv, exp_inx, exp_up;
        string tag;

        // R1: reset state
        sign_i = 1'b1; mag_i = 12'd100; mode_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R1 reset result", int'(result_o), 0);
        check("R1 reset flags", int'({invalid_o, inexact_o, rounded_up_o}), 0);
        rst_n = 1'b1;

        for (int md = 0; md < 4; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int m = 0; m < (1 << (MW - 1)); m++) begin
                    @(negedge clk);
                    sign_i = sg[0]; mag_i = m[MW-1:0]; mode_i = md[1:0];
                    @(negedge clk);
                    flr  = m >> FW;
                    frac = m & ((1 << FW) - 1);
                    rm   = flr;
                    case (md)
                        0: if (frac > 4 || (frac == 4 && (flr % 2) == 1)) rm = flr + 1;
                        1: if (sg == 1 && frac != 0) rm = flr + 1;
                        2: if (sg == 0 && frac != 0) rm = flr + 1;
                        default: rm = flr;
                    endcase
                    v = (sg == 1) ? -rm : rm;
                    exp_inv = (v > (1 << (IW - 1)) - 1) || (v < -(1 << (IW - 1)));
                    exp_res = exp_inv ? (1 << (IW - 1)) : (v & ((1 << IW) - 1));
                    exp_inx = !exp_inv && frac != 0;
                    exp_up  = exp_inx && (rm > flr);
                    if (exp_inv)      tag = "R6 result";
                    else if (sg == 1) tag = "R5 result";
                    else if (md == 0) tag = "R2 result";
                    else if (md == 3) tag = "R3 result";
                    else              tag = "R4 result";
                    check(tag, int'(result_o), exp_res);
                    check("R6 invalid", int'(invalid_o), int'(exp_inv));
                    if (exp_inv)
                        check("R9 flags on invalid", int'({inexact_o, rounded_up_o}), 0);
                    else begin
                        check("R7 inexact", int'(inexact_o), int'(exp_inx));
                        check("R8 rounded_up", int'(rounded_up_o), int'(exp_up));
                    end
                end
            end
        end
        finish_run();
    end
endmodule